// File: doc/BRIEF.md
# MESI Snooping Cache Line Controller

This block keeps coherence for a small private write-back cache that sits on an atomic shared snooping bus. It holds a direct-mapped array of lines, each with a tag, a data word and one of four coherence states: invalid, shared, exclusive-clean or modified. Processor reads and writes that hit in a state that permits them finish locally. All other requests raise a bus request and wait in a transient state until the bus is granted. The transaction then issued is a read, a read-exclusive, an upgrade or a writeback of a dirty victim.

While the cache waits, and at any other time, the block snoops transactions from the other caches. It demotes or invalidates matching lines. It drives the wired-OR shared and dirty response lines, and when its copy is modified it supplies the line's data on the bus. A read-exclusive or upgrade that is won takes the line to modified. The processor's write is then committed in the following cycle, before any snooped exclusive request can take the line away. Without that rule the write could be lost and retried again and again.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is invalid, `bus_req` and `cpu_done` are low, and a snooped read of any address gets neither shared nor dirty asserted.
- R2: The low IDX_W address bits pick the line and the remaining bits form the tag. Bus commands are coded 0 read, 1 read-exclusive, 2 upgrade and 3 writeback. A read miss issues command 0 and fills the line as shared if `bus_shared_in` is high in the grant cycle, or exclusive-clean if it is low. The fill returns `bus_rdata` on `cpu_rdata`.
- R3: A write that hits an exclusive-clean or modified line makes the line modified without raising `bus_req`. A read hit of any valid line also raises no bus request and returns the stored data.
- R4: A write to a shared line issues only an upgrade (2). A write to an invalid or mismatching line issues a read-exclusive (1). In both cases `cpu_done` is high in the cycle after the grant.
- R5: A snooped read-exclusive or upgrade that matches a valid line invalidates it. A snooped read that matches an exclusive-clean or modified line leaves it shared.
- R6: For a snooped read, read-exclusive or upgrade that matches a valid line, `snp_shared` is high. `snp_dirty` is also high when the line is modified, and `snp_data` then carries the line's data. A snooped writeback gets no response.
- R7: If a snooped upgrade or read-exclusive to the same line arrives while an upgrade waits for the bus, the command issued on the grant becomes read-exclusive (1).
- R8: In the cycle after an exclusive grant, a snooped read-exclusive to that line sees `snp_dirty` high with the processor's new write data on `snp_data`, and `cpu_done` is high in that cycle.
- R9: A miss that replaces a clean line issues no writeback. A miss that replaces a modified line first issues a writeback (3) of the old address and data, and then the fill command.
- R10: If a snoop takes the modified victim's data while its writeback waits for the bus, the writeback is dropped and the next grant carries the fill command.
- R11: `cpu_done` is a single-cycle pulse. A hit completes one cycle after the request is accepted, and a read miss completes one cycle after its fill grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until `cpu_done` |
| cpu_we | input | 1 | 1 for write, 0 for read |
| cpu_addr | input | ADDR_W | Request address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_done | output | 1 | Request complete (single-cycle pulse) |
| cpu_rdata | output | DATA_W | Read result, valid with `cpu_done` |
| bus_req | output | 1 | Bus request, high in any transient state |
| bus_gnt | input | 1 | Bus grant; the transaction happens in this cycle |
| bus_valid | output | 1 | This cache owns the bus this cycle |
| bus_cmd | output | 2 | Command of the pending transaction |
| bus_addr | output | ADDR_W | Address of the pending transaction |
| bus_wdata | output | DATA_W | Writeback data |
| bus_shared_in | input | 1 | Wired-OR shared response from other caches |
| bus_rdata | input | DATA_W | Fill data in the grant cycle |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command |
| snp_addr | input | ADDR_W | Snooped address |
| snp_shared | output | 1 | This cache holds a valid copy |
| snp_dirty | output | 1 | This cache holds a modified copy |
| snp_data | output | DATA_W | Data supplied from a modified copy |

## Verification
The hardest situations to reach are the ones where a snoop lands inside a window that opens only after a request has started. These are the upgrade that loses the race while it waits, the writeback whose victim is taken by a snoop first, and the single commit cycle right after an exclusive grant. The bench reaches them by holding back `bus_grant` for a chosen number of cycles and placing the competing snoop on exactly the cycle between request and grant, or between grant and commit. It then checks which command the delayed grant carries and which data the snoop response returns.

// File: rtl/mesi_line_ctrl.sv
`timescale 1ns/1ps
module mesi_line_ctrl #(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_done,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_valid,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_shared_in,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_shared,
  output logic              snp_dirty,
  output logic [DATA_W-1:0] snp_data
);
  localparam int SETS  = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W;

  localparam logic [1:0] ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3;
  localparam logic [1:0] CMD_RD = 2'd0, CMD_RDX = 2'd1, CMD_UPG = 2'd2, CMD_WB = 2'd3;

  typedef enum logic [1:0] {C_IDLE, C_WAIT, C_COMMIT} ctl_t;

  logic [1:0]        st_q  [SETS];
  logic [TAG_W-1:0]  tag_q [SETS];
  logic [DATA_W-1:0] dat_q [SETS];

  ctl_t              ctl_q;
  logic              done_q, wb_q, r_we;
  logic [1:0]        pend_q;
  logic [ADDR_W-1:0] r_addr;
  logic [DATA_W-1:0] r_wdata;

  logic [IDX_W-1:0] c_idx, s_idx, r_idx;
  logic [TAG_W-1:0] c_tag, s_tag, r_tag;
  logic             c_hit, s_act, commit;

  assign c_idx = cpu_addr[IDX_W-1:0];
  assign c_tag = cpu_addr[ADDR_W-1:IDX_W];
  assign s_idx = snp_addr[IDX_W-1:0];
  assign s_tag = snp_addr[ADDR_W-1:IDX_W];
  assign r_idx = r_addr[IDX_W-1:0];
  assign r_tag = r_addr[ADDR_W-1:IDX_W];

  assign c_hit  = (st_q[c_idx] != ST_I) && (tag_q[c_idx] == c_tag);
  assign s_act  = snp_valid && (snp_cmd != CMD_WB) && (st_q[s_idx] != ST_I) && (tag_q[s_idx] == s_tag);
  assign commit = (ctl_q == C_COMMIT);

  assign snp_shared = s_act;
  assign snp_dirty  = s_act && (st_q[s_idx] == ST_M);
  assign snp_data   = (commit && s_idx == r_idx) ? r_wdata : dat_q[s_idx];

  assign bus_req   = (ctl_q == C_WAIT);
  assign bus_valid = bus_req && bus_gnt;
  assign bus_cmd   = wb_q ? CMD_WB : pend_q;
  assign bus_addr  = wb_q ? {tag_q[r_idx], r_idx} : r_addr;
  assign bus_wdata = dat_q[r_idx];

  assign cpu_done = done_q | commit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SETS; i++) begin
        st_q[i]  <= ST_I;
        tag_q[i] <= '0;
        dat_q[i] <= '0;
      end
      ctl_q     <= C_IDLE;
      done_q    <= 1'b0;
      wb_q      <= 1'b0;
      pend_q    <= CMD_RD;
      r_we      <= 1'b0;
      r_addr    <= '0;
      r_wdata   <= '0;
      cpu_rdata <= '0;
    end else begin
      done_q <= 1'b0;
      if (s_act && !bus_valid)
        st_q[s_idx] <= (snp_cmd == CMD_RD) ? ST_S : ST_I;

      case (ctl_q)
        C_IDLE: if (cpu_req && !snp_valid && !done_q) begin
          r_we    <= cpu_we;
          r_addr  <= cpu_addr;
          r_wdata <= cpu_wdata;
          if (c_hit && (!cpu_we || st_q[c_idx] != ST_S)) begin
            done_q <= 1'b1;
            if (cpu_we) begin
              dat_q[c_idx] <= cpu_wdata;
              st_q[c_idx]  <= ST_M;
            end else begin
              cpu_rdata <= dat_q[c_idx];
            end
          end else begin
            ctl_q  <= C_WAIT;
            wb_q   <= !c_hit && (st_q[c_idx] == ST_M);
            pend_q <= c_hit ? CMD_UPG : (cpu_we ? CMD_RDX : CMD_RD);
          end
        end
        C_WAIT: if (bus_gnt) begin
          if (wb_q) begin
            wb_q        <= 1'b0;
            st_q[r_idx] <= ST_I;
          end else begin
            case (pend_q)
              CMD_RD: begin
                tag_q[r_idx] <= r_tag;
                dat_q[r_idx] <= bus_rdata;
                st_q[r_idx]  <= bus_shared_in ? ST_S : ST_E;
                cpu_rdata    <= bus_rdata;
                done_q       <= 1'b1;
                ctl_q        <= C_IDLE;
              end
              CMD_RDX: begin
                tag_q[r_idx] <= r_tag;
                dat_q[r_idx] <= bus_rdata;
                st_q[r_idx]  <= ST_M;
                ctl_q        <= C_COMMIT;
              end
              default: begin
                st_q[r_idx] <= ST_M;
                ctl_q       <= C_COMMIT;
              end
            endcase
          end
        end else if (s_act && s_idx == r_idx) begin
          if (wb_q) wb_q <= 1'b0;
          if (pend_q == CMD_UPG && snp_cmd != CMD_RD) pend_q <= CMD_RDX;
        end
        default: begin
          dat_q[r_idx] <= r_wdata;
          ctl_q        <= C_IDLE;
        end
      endcase
    end
  end

  logic unused_we;
  assign unused_we = r_we;
endmodule

// File: rtl/mesi_line_ctrl_chk.sv
`timescale 1ns/1ps
module mesi_line_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_done,
  input logic       bus_req,
  input logic       bus_valid,
  input logic [1:0] bus_cmd,
  input logic       snp_shared,
  input logic       snp_dirty
);
  a_r6_dirty_implies_shared: assert property (@(posedge clk) disable iff (!rst_n)
    snp_dirty |-> snp_shared);

  a_r4_excl_done_next: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && (bus_cmd == 2'd1 || bus_cmd == 2'd2)) |=> cpu_done);

  a_r2_read_fill_done: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_cmd == 2'd0) |=> cpu_done);

  a_r9_wb_then_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_cmd == 2'd3) |=> bus_req);

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done);
endmodule

bind mesi_line_ctrl mesi_line_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_done(cpu_done), .bus_req(bus_req),
  .bus_valid(bus_valid), .bus_cmd(bus_cmd), .snp_shared(snp_shared), .snp_dirty(snp_dirty)
);

// File: tb/tb_mesi_line_ctrl.sv
`timescale 1ns/1ps
module tb_mesi_line_ctrl;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       cpu_req = 0, cpu_we = 0;
  logic [7:0] cpu_addr = 0, cpu_wdata = 0;
  logic       cpu_done;
  logic [7:0] cpu_rdata;
  logic       bus_req, bus_valid;
  logic       bus_gnt = 0, bus_shared_in = 0;
  logic [1:0] bus_cmd;
  logic [7:0] bus_addr, bus_wdata;
  logic [7:0] bus_rdata = 0;
  logic       snp_valid = 0;
  logic [1:0] snp_cmd = 0;
  logic [7:0] snp_addr = 0;
  logic       snp_shared, snp_dirty;
  logic [7:0] snp_data;

  int tests = 0, fails = 0;
  logic [7:0] mem [256];
  logic [7:0] gold [256];

  always #4 clk = ~clk;

  mesi_line_ctrl dut (.*);

  // {we, shared_in, expected first command (4 = none), addr, wdata}
  localparam logic [20:0] VEC [10] = '{
    {1'b0, 1'b0, 3'd0, 8'h10, 8'h00},
    {1'b1, 1'b0, 3'd4, 8'h10, 8'hA1},
    {1'b0, 1'b0, 3'd4, 8'h10, 8'h00},
    {1'b0, 1'b1, 3'd0, 8'h21, 8'h00},
    {1'b1, 1'b0, 3'd2, 8'h21, 8'hB2},
    {1'b1, 1'b0, 3'd1, 8'h32, 8'hC3},
    {1'b0, 1'b0, 3'd3, 8'h14, 8'h00},
    {1'b0, 1'b0, 3'd0, 8'h10, 8'h00},
    {1'b1, 1'b0, 3'd3, 8'h25, 8'hD4},
    {1'b0, 1'b0, 3'd4, 8'h25, 8'h00}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic we, input logic [7:0] a, input logic [7:0] d,
                        input logic shin, output logic [7:0] rd, output logic [2:0] first);
    first = 3'd4;
    rd = 8'h00;
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    for (int n = 0; n < 50; n++) begin
      @(negedge clk);
      bus_gnt = 0;
      if (cpu_done) begin
        rd = cpu_rdata;
        cpu_req = 0;
        break;
      end
      if (bus_req) begin
        bus_gnt = 1;
        bus_shared_in = shin;
        bus_rdata = mem[bus_addr];
        if (first == 3'd4) first = {1'b0, bus_cmd};
        if (bus_cmd == 2'd3) mem[bus_addr] = bus_wdata;
      end
    end
    if (we) gold[a] = d;
  endtask

  task automatic snoop(input logic [1:0] cmd, input logic [7:0] a,
                       output logic sh, output logic dt, output logic [7:0] data);
    @(negedge clk);
    snp_valid = 1; snp_cmd = cmd; snp_addr = a;
    #1;
    sh = snp_shared; dt = snp_dirty; data = snp_data;
    @(negedge clk);
    snp_valid = 0;
    if (dt) mem[a] = data;
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] rd, sd;
    logic [2:0] fc;
    logic sh, dt;
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i) ^ 8'h5A;
      gold[i] = 8'(i) ^ 8'h5A;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 done low", cpu_done, 0);
    chk("R1 no bus_req", bus_req, 0);
    snoop(2'd0, 8'h10, sh, dt, sd);
    chk("R1 snoop shared after reset", sh, 0);

    for (int v = 0; v < 10; v++) begin
      logic [20:0] e;
      e = VEC[v];
      run_op(e[20], e[15:8], e[7:0], e[19], rd, fc);
      chk($sformatf("R2/R3/R4/R9 vector %0d first cmd", v), fc, e[18:16]);
      if (!e[20]) chk($sformatf("R2/R3 vector %0d rdata", v), rd, gold[e[15:8]]);
    end

    // R5/R6: 0x10 is exclusive-clean now
    snoop(2'd0, 8'h10, sh, dt, sd);
    chk("R6 E snoop shared", sh, 1);
    chk("R6 E snoop not dirty", dt, 0);
    run_op(1'b1, 8'h10, 8'h66, 1'b0, rd, fc);
    chk("R5 demoted E now needs upgrade", fc, 3'd2);
    snoop(2'd0, 8'h10, sh, dt, sd);
    chk("R6 M snoop dirty", dt, 1);
    chk("R6 M snoop data", sd, 8'h66);
    snoop(2'd1, 8'h10, sh, dt, sd);
    chk("R5 S snoop rdx shared", sh, 1);
    snoop(2'd0, 8'h10, sh, dt, sd);
    chk("R5 invalidated by rdx", sh, 0);
    snoop(2'd3, 8'h25, sh, dt, sd);
    chk("R6 writeback snoop ignored", sh, 0);

    // R7: upgrade race on 0x03
    run_op(1'b0, 8'h03, 8'h00, 1'b1, rd, fc);
    @(negedge clk);
    cpu_req = 1; cpu_we = 1; cpu_addr = 8'h03; cpu_wdata = 8'h9D;
    @(negedge clk);
    chk("R4 upgrade request raised", bus_req, 1);
    snp_valid = 1; snp_cmd = 2'd2; snp_addr = 8'h03;
    #1;
    chk("R6 waiting S line shared", snp_shared, 1);
    @(negedge clk);
    snp_valid = 0;
    bus_gnt = 1; bus_rdata = mem[8'h03];
    #1;
    chk("R7 lost upgrade becomes rdx", bus_cmd, 2'd1);
    @(negedge clk);
    bus_gnt = 0;
    chk("R4 done after exclusive grant", cpu_done, 1);
    cpu_req = 0;
    gold[8'h03] = 8'h9D;
    snoop(2'd1, 8'h03, sh, dt, sd);
    chk("R5 rdx flush of M data", sd, 8'h9D);

    // R8: hold-until-write on 0x07
    @(negedge clk);
    cpu_req = 1; cpu_we = 1; cpu_addr = 8'h07; cpu_wdata = 8'hC5;
    @(negedge clk);
    bus_gnt = 1; bus_rdata = mem[8'h07];
    #1;
    chk("R4 write miss issues rdx", bus_cmd, 2'd1);
    @(negedge clk);
    bus_gnt = 0;
    snp_valid = 1; snp_cmd = 2'd1; snp_addr = 8'h07;
    #1;
    chk("R8 commit cycle done", cpu_done, 1);
    chk("R8 snoop sees dirty", snp_dirty, 1);
    chk("R8 snoop sees new write", snp_data, 8'hC5);
    mem[8'h07] = snp_data;
    cpu_req = 0;
    gold[8'h07] = 8'hC5;
    @(negedge clk);
    snp_valid = 0;
    snoop(2'd0, 8'h07, sh, dt, sd);
    chk("R8 line released after write", sh, 0);
    run_op(1'b0, 8'h07, 8'h00, 1'b0, rd, fc);
    chk("R8 refetched value", rd, 8'hC5);

    // R10: writeback of 0x25 dropped after snoop flush
    @(negedge clk);
    cpu_req = 1; cpu_we = 0; cpu_addr = 8'h29;
    @(negedge clk);
    chk("R9 dirty victim writeback first", bus_cmd, 2'd3);
    snp_valid = 1; snp_cmd = 2'd0; snp_addr = 8'h25;
    #1;
    chk("R10 victim flush data", snp_data, gold[8'h25]);
    mem[8'h25] = snp_data;
    @(negedge clk);
    snp_valid = 0;
    bus_gnt = 1; bus_shared_in = 0; bus_rdata = mem[8'h29];
    #1;
    chk("R10 grant carries fill", bus_cmd, 2'd0);
    @(negedge clk);
    bus_gnt = 0;
    chk("R11 read miss done after grant", cpu_done, 1);
    chk("R2 fill data", cpu_rdata, gold[8'h29]);
    cpu_req = 0;
    @(negedge clk);
    chk("R11 done single pulse", cpu_done, 0);
    run_op(1'b0, 8'h25, 8'h00, 1'b0, rd, fc);
    chk("R10 flushed value in memory", rd, 8'hD4);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule